// File: doc/BRIEF.md
# Package Idle-State Controller with Last-Level Cache Sizing

This block merges the idle-state requests of several cores into a single package idle state and derives the package power controls from it. Each core presents a 4-bit idle-state code, where 0 is the active state and larger codes are deeper. The package state is the shallowest of the requests, further limited by a platform depth cap. The cap stands in for display, refresh and device-latency limits. The resolved state is registered. From it the block produces an enable for the internally generated rails, a supply target code, and a flag that puts the external regulator into its deepest low-power mode.

The block also owns the enable mask of the last-level cache ways. While the package sits at state 7 or deeper, the mask is shrunk from the highest-numbered way downward, a fixed number of ways per step and one step per interval. If every core hints for a bulk flush, the mask is cleared at once instead. When the package returns to the active state, ways are re-enabled from the lowest-numbered way upward at the same step size and interval. Moving cache data and regulating voltages are left to other blocks.

Top module: `pkg_cstate_ctrl`

## Requirements
- R1: One clock edge after the request inputs change, `pkg_state_o` equals the smallest of the per-core 4-bit requests (core k occupies bits 4k+3..4k of `core_req_i`), limited by the cap.
- R2: When any core requests 0 (active), `pkg_state_o` is 0 after the next clock edge, and the rail enable and supply code show their active values in that same cycle, before any cache way is restored.
- R3: The package state never exceeds `depth_cap_i` as sampled at the preceding edge; the package state is min(shallowest request, cap).
- R4: `rail_en_o` is 0 exactly when the package state is 8 or deeper.
- R5: `vcc_code_o` is 2 (nominal) for states below 8, 1 (retention) in state 8, and 0 (off) in states 9 and deeper.
- R6: `vr_lowpwr_o` is 1 exactly when the package state is 10 or deeper.
- R7: After reset the package state is 0, all ways are enabled, the rails are enabled and the supply code is 2.
- R8: The way mask does not change while the package state is between 1 and 6.
- R9: While the package state is 7 or deeper and the bulk hint is not held, the mask loses FLUSH_STEP ways from the top at the end of every STEP_INTERVAL-th cycle spent in that state, stopping at zero ways.
- R10: If all bits of `flush_all_hint_i` are 1 when a deep package state (7 or deeper) is resolved, every way is disabled at the first edge during which that state is shown.
- R11: In package state 0 the mask regains FLUSH_STEP ways, lowest first, every STEP_INTERVAL cycles, stopping when all ways are on.
- R12: An exit to state 0 during a gradual flush abandons the flush. The interval count restarts, and restoration starts from the mask as it stood.
- R13: The mask is always contiguous from way 0: enabled ways form a block that starts at bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| core_req_i | input | 4*NUM_CORES | Per-core idle-state request, 4 bits per core |
| flush_all_hint_i | input | NUM_CORES | Per-core hint asking for a bulk flush |
| depth_cap_i | input | 4 | Deepest package state allowed by the platform |
| pkg_state_o | output | 4 | Resolved package idle state |
| rail_en_o | output | 1 | Enable for the internally generated rails |
| vcc_code_o | output | 2 | Supply target: 2 nominal, 1 retention, 0 off |
| vr_lowpwr_o | output | 1 | External regulator deepest low-power mode |
| llc_way_en_o | output | LLC_WAYS | Per-way cache enable mask |

## Verification
The hardest situation to reach is an exit to the active state while a gradual flush is only partly done. That case needs every core to stay deep for several whole intervals, which independent random requests almost never produce. The stimulus therefore runs phases in which all cores draw deep codes under a high cap. These phases alternate with active and shallow phases of random length, so that exits land at every point of the interval counter. Directed sequences also stop a flush after exactly two steps and follow the restoration from the half-filled mask.

// File: rtl/pcst_pkg.sv
package pcst_pkg;
   localparam int unsigned ST_W = 4;
   typedef logic [ST_W-1:0] cstate_t;

   localparam cstate_t ST_ACTIVE    = 4'd0;
   localparam cstate_t ST_FLUSH_MIN = 4'd7;
   localparam cstate_t ST_RAIL_OFF  = 4'd8;
   localparam cstate_t ST_VCC_OFF   = 4'd9;
   localparam cstate_t ST_VR_DEEP   = 4'd10;

   typedef enum logic [1:0] {
      VCC_OFF     = 2'd0,
      VCC_RETAIN  = 2'd1,
      VCC_NOMINAL = 2'd2
   } vcc_code_e;

   typedef enum logic [1:0] {
      SZ_HOLD   = 2'd0,
      SZ_SHRINK = 2'd1,
      SZ_GROW   = 2'd2
   } size_mode_e;

   function automatic size_mode_e mode_of(cstate_t s);
      if (s == ST_ACTIVE)         return SZ_GROW;
      else if (s >= ST_FLUSH_MIN) return SZ_SHRINK;
      else                        return SZ_HOLD;
   endfunction
endpackage

// File: rtl/pcst_resolver.sv
module pcst_resolver
   import pcst_pkg::*;
#(
   parameter int unsigned NUM_CORES = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [ST_W*NUM_CORES-1:0] req_i,
   input  logic [NUM_CORES-1:0]      hint_i,
   input  cstate_t                   cap_i,
   output cstate_t                   state_d_o,
   output cstate_t                   state_q_o,
   output logic                      bulk_q_o
);
   cstate_t req_min;
   cstate_t state_q;
   logic    bulk_q;

   generate
      if (NUM_CORES == 1) begin : g_single
         assign req_min = req_i[ST_W-1:0];
      end else begin : g_multi
         always_comb begin
            req_min = req_i[ST_W-1:0];
            for (int k = 1; k < NUM_CORES; k++) begin
               if (req_i[k*ST_W +: ST_W] < req_min) req_min = req_i[k*ST_W +: ST_W];
            end
         end
      end
   endgenerate

   assign state_d_o = (cap_i < req_min) ? cap_i : req_min;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_ACTIVE;
         bulk_q  <= 1'b0;
      end else begin
         state_q <= state_d_o;
         bulk_q  <= &hint_i;
      end
   end

   assign state_q_o = state_q;
   assign bulk_q_o  = bulk_q;
endmodule

// File: rtl/pcst_power_map.sv
module pcst_power_map
   import pcst_pkg::*;
(
   input  cstate_t    state_i,
   output logic       rail_en_o,
   output logic [1:0] vcc_code_o,
   output logic       vr_lowpwr_o
);
   vcc_code_e vcc;

   always_comb begin
      if (state_i >= ST_VCC_OFF)        vcc = VCC_OFF;
      else if (state_i >= ST_RAIL_OFF)  vcc = VCC_RETAIN;
      else                              vcc = VCC_NOMINAL;
   end

   assign rail_en_o   = (state_i < ST_RAIL_OFF);
   assign vcc_code_o  = vcc;
   assign vr_lowpwr_o = (state_i >= ST_VR_DEEP);
endmodule

// File: rtl/pcst_llc_sizer.sv
module pcst_llc_sizer
   import pcst_pkg::*;
#(
   parameter int unsigned LLC_WAYS      = 16,
   parameter int unsigned FLUSH_STEP    = 4,
   parameter int unsigned STEP_INTERVAL = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  cstate_t             state_q_i,
   input  cstate_t             state_d_i,
   input  logic                bulk_q_i,
   output logic [LLC_WAYS-1:0] way_en_o
);
   localparam int unsigned CNT_W  = $clog2(LLC_WAYS + 1);
   localparam int unsigned TICK_W = (STEP_INTERVAL > 1) ? $clog2(STEP_INTERVAL) : 1;
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(LLC_WAYS);
   localparam logic [CNT_W-1:0] CNT_STEP = CNT_W'(FLUSH_STEP);

   size_mode_e       mode_cur, mode_nxt;
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             step;

   assign mode_cur = mode_of(state_q_i);
   assign mode_nxt = mode_of(state_d_i);

   generate
      if (STEP_INTERVAL == 1) begin : g_every_cycle
         assign step = (mode_cur != SZ_HOLD);
      end else begin : g_interval
         localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(STEP_INTERVAL - 1);
         logic [TICK_W-1:0] tick_q;
         assign step = (mode_cur != SZ_HOLD) && (tick_q == TICK_LAST);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               tick_q <= '0;
            else if ((mode_nxt != mode_cur) || (mode_nxt == SZ_HOLD) || step)
               tick_q <= '0;
            else
               tick_q <= tick_q + 1'b1;
         end
      end
   endgenerate

   always_comb begin
      cnt_d = cnt_q;
      unique case (mode_cur)
         SZ_SHRINK: begin
            if (bulk_q_i)             cnt_d = '0;
            else if (step)            cnt_d = (cnt_q > CNT_STEP) ? cnt_q - CNT_STEP : '0;
         end
         SZ_GROW: begin
            if (step)                 cnt_d = (cnt_q > CNT_FULL - CNT_STEP) ? CNT_FULL : cnt_q + CNT_STEP;
         end
         default: cnt_d = cnt_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= CNT_FULL;
      else        cnt_q <= cnt_d;
   end

   for (genvar w = 0; w < LLC_WAYS; w++) begin : g_way
      assign way_en_o[w] = (CNT_W'(w) < cnt_q);
   end
endmodule

// File: rtl/pkg_cstate_ctrl.sv
module pkg_cstate_ctrl
   import pcst_pkg::*;
#(
   parameter int unsigned NUM_CORES     = 4,
   parameter int unsigned LLC_WAYS      = 16,
   parameter int unsigned FLUSH_STEP    = 4,
   parameter int unsigned STEP_INTERVAL = 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [4*NUM_CORES-1:0]    core_req_i,
   input  logic [NUM_CORES-1:0]      flush_all_hint_i,
   input  logic [3:0]                depth_cap_i,
   output logic [3:0]                pkg_state_o,
   output logic                      rail_en_o,
   output logic [1:0]                vcc_code_o,
   output logic                      vr_lowpwr_o,
   output logic [LLC_WAYS-1:0]       llc_way_en_o
);
   generate
      if (NUM_CORES < 1) begin : g_bad_cores
         $error("NUM_CORES must be at least 1");
      end
      if (FLUSH_STEP < 1 || FLUSH_STEP > LLC_WAYS) begin : g_bad_step
         $error("FLUSH_STEP must lie in 1..LLC_WAYS");
      end
      if (STEP_INTERVAL < 1) begin : g_bad_interval
         $error("STEP_INTERVAL must be at least 1");
      end
   endgenerate

   cstate_t st_d, st_q;
   logic    bulk_q;

   pcst_resolver #(.NUM_CORES(NUM_CORES)) u_resolver (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_i     (core_req_i),
      .hint_i    (flush_all_hint_i),
      .cap_i     (depth_cap_i),
      .state_d_o (st_d),
      .state_q_o (st_q),
      .bulk_q_o  (bulk_q)
   );

   pcst_power_map u_power (
      .state_i     (st_q),
      .rail_en_o   (rail_en_o),
      .vcc_code_o  (vcc_code_o),
      .vr_lowpwr_o (vr_lowpwr_o)
   );

   pcst_llc_sizer #(
      .LLC_WAYS      (LLC_WAYS),
      .FLUSH_STEP    (FLUSH_STEP),
      .STEP_INTERVAL (STEP_INTERVAL)
   ) u_sizer (
      .clk       (clk),
      .rst_n     (rst_n),
      .state_q_i (st_q),
      .state_d_i (st_d),
      .bulk_q_i  (bulk_q),
      .way_en_o  (llc_way_en_o)
   );

   assign pkg_state_o = st_q;
endmodule

// File: rtl/pcst_checker.sv
module pcst_checker #(
   parameter int unsigned NUM_CORES  = 4,
   parameter int unsigned LLC_WAYS   = 16,
   parameter int unsigned FLUSH_STEP = 4
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic [4*NUM_CORES-1:0] core_req_i,
   input logic [3:0]             depth_cap_i,
   input logic [3:0]             pkg_state_o,
   input logic                   rail_en_o,
   input logic [1:0]             vcc_code_o,
   input logic                   vr_lowpwr_o,
   input logic [LLC_WAYS-1:0]    llc_way_en_o
);
   logic any_active;
   always_comb begin
      any_active = 1'b0;
      for (int k = 0; k < NUM_CORES; k++)
         if (core_req_i[4*k +: 4] == 4'd0) any_active = 1'b1;
   end

   // R2: an active core pulls the package to C0 with active power controls
   a_r2_exit_to_active: assert property (@(posedge clk) disable iff (!rst_n)
      any_active |=> (pkg_state_o == 4'd0) && rail_en_o && (vcc_code_o == 2'd2));

   // R3: cap respected
   a_r3_cap_limit: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (pkg_state_o <= $past(depth_cap_i)));

   // R6: regulator deep mode implies supply off and rails off
   a_r6_vr_deep_implies_off: assert property (@(posedge clk) disable iff (!rst_n)
      vr_lowpwr_o |-> (vcc_code_o == 2'd0) && !rail_en_o);

   // R4: rails off only in state 8 or deeper
   a_r4_rails_off_deep: assert property (@(posedge clk) disable iff (!rst_n)
      !rail_en_o |-> (pkg_state_o >= 4'd8));

   // R8: mask frozen in shallow idle states
   a_r8_hold_shallow: assert property (@(posedge clk) disable iff (!rst_n)
      (pkg_state_o != 4'd0 && pkg_state_o < 4'd7) |=> $stable(llc_way_en_o));

   // R11: ways come back only from the active state and never more than a step
   a_r11_grow_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ($countones(llc_way_en_o) <= $countones($past(llc_way_en_o)) + FLUSH_STEP));

   a_r11_grow_only_active: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(pkg_state_o) != 4'd0) |-> ($countones(llc_way_en_o) <= $countones($past(llc_way_en_o))));

   // R13: mask contiguous from way 0
   a_r13_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
      ((llc_way_en_o & (llc_way_en_o + 1'b1)) == '0));
endmodule

bind pkg_cstate_ctrl pcst_checker #(
   .NUM_CORES  (NUM_CORES),
   .LLC_WAYS   (LLC_WAYS),
   .FLUSH_STEP (FLUSH_STEP)
) u_pcst_checker (
   .clk          (clk),
   .rst_n        (rst_n),
   .core_req_i   (core_req_i),
   .depth_cap_i  (depth_cap_i),
   .pkg_state_o  (pkg_state_o),
   .rail_en_o    (rail_en_o),
   .vcc_code_o   (vcc_code_o),
   .vr_lowpwr_o  (vr_lowpwr_o),
   .llc_way_en_o (llc_way_en_o)
);

// File: tb/pkg_cstate_ctrl_tb.sv
module pkg_cstate_ctrl_tb_top;
   localparam int NC = 4;
   localparam int NW = 16;
   localparam int NS = 4;
   localparam int NI = 8;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [4*NC-1:0] core_req_i = '0;
   logic [NC-1:0]   flush_all_hint_i = '0;
   logic [3:0]      depth_cap_i = 4'd15;
   logic [3:0]      pkg_state_o;
   logic            rail_en_o;
   logic [1:0]      vcc_code_o;
   logic            vr_lowpwr_o;
   logic [NW-1:0]   llc_way_en_o;

   always #4 clk = ~clk;

   pkg_cstate_ctrl #(.NUM_CORES(NC), .LLC_WAYS(NW), .FLUSH_STEP(NS), .STEP_INTERVAL(NI)) dut_i (
      .clk(clk), .rst_n(rst_n), .core_req_i(core_req_i), .flush_all_hint_i(flush_all_hint_i),
      .depth_cap_i(depth_cap_i), .pkg_state_o(pkg_state_o), .rail_en_o(rail_en_o),
      .vcc_code_o(vcc_code_o), .vr_lowpwr_o(vr_lowpwr_o), .llc_way_en_o(llc_way_en_o));

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   // reference state
   int m_pkg = 0, m_cnt = NW, m_tick = 0;
   bit m_bulk = 0;
   string m_pkg_tag = "R1";

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic int mode_of(int s);
      if (s == 0) return 2;
      if (s >= 7) return 1;
      return 0;
   endfunction

   function automatic int exp_mask(int n);
      int m = 0;
      for (int i = 0; i < n; i++) m |= (1 << i);
      return m;
   endfunction

   function automatic int exp_vcc(int s);
      if (s >= 9) return 0;
      if (s == 8) return 1;
      return 2;
   endfunction

   task automatic step_cycle(input logic [4*NC-1:0] req, input logic [NC-1:0] hint, input logic [3:0] cap);
      int mn, n_pkg, cur, nxt, stp, n_cnt, n_tick;
      string mtag;
      core_req_i = req; flush_all_hint_i = hint; depth_cap_i = cap;
      mn = 15;
      for (int k = 0; k < NC; k++) if (int'(req[4*k +: 4]) < mn) mn = int'(req[4*k +: 4]);
      n_pkg = (int'(cap) < mn) ? int'(cap) : mn;
      cur = mode_of(m_pkg); nxt = mode_of(n_pkg);
      stp = (cur != 0) && (m_tick == NI - 1);
      n_cnt = m_cnt;
      if (cur == 1 && m_bulk) n_cnt = 0;
      else if (cur == 1 && stp) n_cnt = (m_cnt > NS) ? m_cnt - NS : 0;
      else if (cur == 2 && stp) n_cnt = (m_cnt > NW - NS) ? NW : m_cnt + NS;
      n_tick = (nxt != cur || nxt == 0 || stp) ? 0 : m_tick + 1;
      mtag = (cur == 1) ? (m_bulk ? "R10" : "R9") : (cur == 2 ? "R11" : "R8");
      m_pkg_tag = (mn == 0) ? "R2" : ((int'(cap) < mn) ? "R3" : "R1");
      m_pkg = n_pkg; m_cnt = n_cnt; m_tick = n_tick; m_bulk = &hint;
      @(posedge clk); #4;
      chk(m_pkg_tag, int'(pkg_state_o), m_pkg);
      chk("R4", int'(rail_en_o), (m_pkg < 8) ? 1 : 0);
      chk("R5", int'(vcc_code_o), exp_vcc(m_pkg));
      chk("R6", int'(vr_lowpwr_o), (m_pkg >= 10) ? 1 : 0);
      chk(mtag, int'(llc_way_en_o), exp_mask(m_cnt));
      chk("R13", int'((llc_way_en_o & (llc_way_en_o + 1'b1)) == '0), 1);
   endtask

   function automatic logic [4*NC-1:0] all_req(int s);
      logic [4*NC-1:0] r;
      for (int k = 0; k < NC; k++) r[4*k +: 4] = 4'(s);
      return r;
   endfunction

   initial begin
      #(200000 * 8);
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      #4;
      // R7: reset values
      chk("R7", int'(pkg_state_o), 0);
      chk("R7", int'(llc_way_en_o), exp_mask(NW));
      chk("R7", int'(rail_en_o), 1);
      chk("R7", int'(vcc_code_o), 2);
      rst_n = 1'b1;
      @(posedge clk); #4;

      // R9: full gradual flush in state 8
      repeat (NI * 5) step_cycle(all_req(8), '0, 4'd15);
      chk("R9", int'(llc_way_en_o), 0);
      // R11: restore fully
      repeat (NI * 5) step_cycle(all_req(0), '0, 4'd15);
      chk("R11", int'(llc_way_en_o), exp_mask(NW));

      // R12: exit after exactly two steps
      repeat (NI * 2 + 1) step_cycle(all_req(9), '0, 4'd15);
      chk("R12", int'(llc_way_en_o), exp_mask(NW - 2 * NS));
      step_cycle({all_req(9)} & ~16'h000F, '0, 4'd15);
      chk("R2", int'(rail_en_o), 1);
      chk("R12", int'(llc_way_en_o), exp_mask(NW - 2 * NS));
      repeat (NI) step_cycle(all_req(0), '0, 4'd15);
      chk("R12", int'(llc_way_en_o), exp_mask(NW - NS));
      repeat (NI) step_cycle(all_req(0), '0, 4'd15);

      // R10: bulk flush at C10
      step_cycle(all_req(10), '1, 4'd15);
      chk("R6", int'(vr_lowpwr_o), 1);
      step_cycle(all_req(10), '1, 4'd15);
      chk("R10", int'(llc_way_en_o), 0);
      repeat (NI * 4) step_cycle(all_req(0), '0, 4'd15);

      // R3/R8: cap at 5 holds mask despite deep requests
      repeat (NI * 3) step_cycle(all_req(12), '1, 4'd5);
      chk("R3", int'(pkg_state_o), 5);
      chk("R8", int'(llc_way_en_o), exp_mask(NW));

      // random phases
      for (int ph = 0; ph < 120; ph++) begin
         int kind = $urandom_range(0, 3);
         int len  = $urandom_range(3, 40);
         for (int c = 0; c < len; c++) begin
            logic [4*NC-1:0] r;
            logic [NC-1:0]   h;
            logic [3:0]      cp;
            for (int k = 0; k < NC; k++) begin
               if (kind == 0)      r[4*k +: 4] = 4'($urandom_range(7, 12));
               else if (kind == 1) r[4*k +: 4] = 4'($urandom_range(0, 15));
               else if (kind == 2) r[4*k +: 4] = 4'($urandom_range(1, 6));
               else                r[4*k +: 4] = 4'd0;
            end
            h  = ($urandom_range(0, 3) == 0) ? '1 : NC'($urandom);
            cp = ($urandom_range(0, 4) == 0) ? 4'($urandom_range(0, 15)) : 4'd15;
            step_cycle(r, h, cp);
         end
      end

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule